// File: doc/BRIEF.md
# Rank Power State Controller

This block follows the power state of a single DRAM rank. The rank is in one of six states: idle with every bank closed, active with at least one bank open, active power-down, precharge power-down, auto-refresh, or self-refresh. The block watches the number of open banks, whether the read and write queues for the rank are empty, the direction of the data bus, and the number of activate, read and write events still in flight. A separate refresh timer supplies begin and end indications.

From these inputs the block decides when to enter and leave the low-power states. It emits one-cycle power-down and self-refresh entry and exit commands. After any exit it holds a command-ready signal low for the exit latency. When a refresh starts, the block records whether the rank was idle or in precharge power-down. When the refresh ends, it uses that record to choose the next state, so self-refresh can only follow a refresh that began in precharge power-down. One free-running cycle counter per state records how long the rank has spent in each state, as an input to power estimates made elsewhere.

Top module: `rank_power_fsm`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the state is idle, all four command pulses are 0, `cmdReady` is 1 and every state cycle counter is 0.
- R2: The `pwrState` encoding is idle=0, active=1, active power-down=2, precharge power-down=3, refresh=4, self-refresh=5. In idle, the choices are taken in priority order: `refBegin` moves to refresh; otherwise a nonzero `activeBanks` moves to active; otherwise a quiet rank moves to precharge power-down with a `pdEnter` pulse.
- R3: A rank is quiet when both queues are empty and `pendingEvents` is zero. Power-down is entered only when the rank is quiet. A nonzero `pendingEvents` keeps the rank out of power-down even when both queues are empty.
- R4: In active, an `activeBanks` of zero moves to idle. Otherwise a quiet rank moves to active power-down with a `pdEnter` pulse. `refBegin` has no effect in active.
- R5: Active power-down leaves only to active. It leaves when either queue is non-empty, with a `pdExit` pulse. An `activeBanks` of zero does not move it.
- R6: In precharge power-down, `refBegin` moves to refresh with a `pdExit` pulse. Otherwise a non-empty queue moves to idle with a `pdExit` pulse.
- R7: When `refEnd` is seen in refresh, the next state depends on the state recorded when the refresh began. If that state was idle, the rank returns to idle. If it was precharge power-down and the rank is quiet, the rank enters self-refresh with an `srEnter` pulse. If it was precharge power-down and the rank is not quiet, the rank goes to idle.
- R8: Self-refresh leaves only to idle, with an `srExit` pulse. It leaves when the read queue is non-empty, or when the write queue is non-empty and `busWrite` is 1. Queued writes with `busWrite` at 0 have no effect. At most one command pulse is high in any cycle.
- R9: After a `pdExit` pulse, `cmdReady` stays 0 for TXP cycles. After an `srExit` pulse, it stays 0 for TXS cycles. The count includes the cycle of the pulse.
- R10: `lowPower` is 1 whenever the current state or the state about to be entered is active power-down, precharge power-down or self-refresh.
- R11: Each state's counter in `stateCycles` (indexed by the R2 encoding) grows by one for every clock cycle spent in that state after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| activeBanks | input | BANKW | Number of open banks in the rank |
| rdEmpty | input | 1 | Read queue holds nothing for this rank |
| wrEmpty | input | 1 | Write queue holds nothing for this rank |
| busWrite | input | 1 | Data bus is currently turned for writes |
| pendingEvents | input | EVW | Activate/read/write events still outstanding |
| refBegin | input | 1 | Refresh timer asks to start a refresh |
| refEnd | input | 1 | Refresh has completed |
| pwrState | output | 3 | Current power state (R2 encoding) |
| lowPower | output | 1 | In or entering a low-power state |
| pdEnter | output | 1 | Power-down entry command pulse |
| pdExit | output | 1 | Power-down exit command pulse |
| srEnter | output | 1 | Self-refresh entry command pulse |
| srExit | output | 1 | Self-refresh exit command pulse |
| cmdReady | output | 1 | Next command may issue (wake-up delay elapsed) |
| stateCycles | output | 6*CNTW | Per-state cycle counters, index = state code |

## Verification
A wrong recorded pre-refresh state shows at `refEnd`: the rank lands in self-refresh when it should land in idle, or the reverse, and `srEnter` pulses or stays silent on that same cycle. A wrong transition shows on `pwrState` on the clock after the triggering input. It also shows later as a per-state counter that drifts away from the tally the bench keeps. A wake-up count off by one shows as `cmdReady` rising a cycle early or late, right at the end of the TXP or TXS window.

// File: rtl/rankpwr_pkg.sv
package rankpwr_pkg;
  localparam int NUM_PWR_STATES = 6;

  typedef enum logic [2:0] {
    PS_IDLE    = 3'd0,
    PS_ACT     = 3'd1,
    PS_ACT_PDN = 3'd2,
    PS_PRE_PDN = 3'd3,
    PS_REF     = 3'd4,
    PS_SREF    = 3'd5
  } pwrState_t;

  typedef struct packed {
    logic enterPd;
    logic exitPd;
    logic enterSr;
    logic exitSr;
  } pwrStrobe_t;

  function automatic logic isLowPower(pwrState_t s);
    return (s == PS_ACT_PDN) || (s == PS_PRE_PDN) || (s == PS_SREF);
  endfunction
endpackage

// File: rtl/rankpwr_ctrl.sv
module rankpwr_ctrl
  import rankpwr_pkg::*;
#(
  parameter int BANKW = 4,
  parameter int EVW   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BANKW-1:0] activeBanks,
  input  logic             rdEmpty,
  input  logic             wrEmpty,
  input  logic             busWrite,
  input  logic [EVW-1:0]   pendingEvents,
  input  logic             refBegin,
  input  logic             refEnd,
  output pwrState_t        state,
  output logic             lowPower,
  output pwrStrobe_t       strobe
);
  pwrState_t nextState;
  pwrState_t priorState;

  logic quiet, anyQueued, forceSrExit;
  assign quiet       = rdEmpty && wrEmpty && (pendingEvents == '0);
  assign anyQueued   = !rdEmpty || !wrEmpty;
  assign forceSrExit = !rdEmpty || (busWrite && !wrEmpty);

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      PS_IDLE: begin
        if (refBegin) nextState = PS_REF;
        else if (activeBanks != '0) nextState = PS_ACT;
        else if (quiet) begin
          nextState = PS_PRE_PDN;
          strobe.enterPd = 1'b1;
        end
      end
      PS_ACT: begin
        if (activeBanks == '0) nextState = PS_IDLE;
        else if (quiet) begin
          nextState = PS_ACT_PDN;
          strobe.enterPd = 1'b1;
        end
      end
      PS_ACT_PDN: begin
        if (anyQueued) begin
          nextState = PS_ACT;
          strobe.exitPd = 1'b1;
        end
      end
      PS_PRE_PDN: begin
        if (refBegin) begin
          nextState = PS_REF;
          strobe.exitPd = 1'b1;
        end else if (anyQueued) begin
          nextState = PS_IDLE;
          strobe.exitPd = 1'b1;
        end
      end
      PS_REF: begin
        if (refEnd) begin
          if (priorState == PS_PRE_PDN && quiet) begin
            nextState = PS_SREF;
            strobe.enterSr = 1'b1;
          end else begin
            nextState = PS_IDLE;
          end
        end
      end
      PS_SREF: begin
        if (forceSrExit) begin
          nextState = PS_IDLE;
          strobe.exitSr = 1'b1;
        end
      end
      default: nextState = PS_IDLE;
    endcase
  end

  assign lowPower = isLowPower(state) || isLowPower(nextState);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= PS_IDLE;
      priorState <= PS_IDLE;
    end else begin
      state <= nextState;
      if (nextState == PS_REF && state != PS_REF) priorState <= state;
    end
  end

  // Active power-down may only return to active
  assert_actpdn_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    state == PS_ACT_PDN |=> (state == PS_ACT_PDN || state == PS_ACT));

  // Self-refresh is reached only from a refresh that began in precharge power-down
  assert_sref_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_SREF && $past(state) != PS_SREF) |->
      ($past(state) == PS_REF && $past(priorState) == PS_PRE_PDN));

  // Self-refresh exits only to idle
  assert_sref_exit_R8: assert property (@(posedge clk) disable iff (!rstN)
    state == PS_SREF |=> (state == PS_SREF || state == PS_IDLE));

  // Power-down entered from idle only with nothing outstanding
  assert_pd_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_PRE_PDN && $past(state) == PS_IDLE) |->
      ($past(pendingEvents) == '0 && $past(rdEmpty) && $past(wrEmpty)));
endmodule

// File: rtl/rankpwr_datapath.sv
module rankpwr_datapath
  import rankpwr_pkg::*;
#(
  parameter int TXP  = 4,
  parameter int TXS  = 10,
  parameter int CNTW = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  pwrState_t  state,
  input  pwrStrobe_t strobe,
  output logic       pdEnter,
  output logic       pdExit,
  output logic       srEnter,
  output logic       srExit,
  output logic       cmdReady,
  output logic [NUM_PWR_STATES-1:0][CNTW-1:0] stateCycles
);
  localparam int WAKEMAX = (TXS > TXP) ? TXS : TXP;
  localparam int WAKEW   = $clog2(WAKEMAX + 1);

  logic [WAKEW-1:0] wakeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdEnter <= 1'b0;
      pdExit  <= 1'b0;
      srEnter <= 1'b0;
      srExit  <= 1'b0;
      wakeCnt <= '0;
    end else begin
      pdEnter <= strobe.enterPd;
      pdExit  <= strobe.exitPd;
      srEnter <= strobe.enterSr;
      srExit  <= strobe.exitSr;
      if (strobe.exitSr)      wakeCnt <= WAKEW'(TXS);
      else if (strobe.exitPd) wakeCnt <= WAKEW'(TXP);
      else if (wakeCnt != '0) wakeCnt <= wakeCnt - 1'b1;
    end
  end

  assign cmdReady = (wakeCnt == '0);

  for (genvar g = 0; g < NUM_PWR_STATES; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stateCycles[g] <= '0;
      else if (state == pwrState_t'(g)) stateCycles[g] <= stateCycles[g] + 1'b1;
    end
  end

  // Exit latency window starts at its full length
  assert_wake_pd_R9: assert property (@(posedge clk) disable iff (!rstN)
    pdExit |-> (wakeCnt == WAKEW'(TXP)));
  assert_wake_sr_R9: assert property (@(posedge clk) disable iff (!rstN)
    srExit |-> (wakeCnt == WAKEW'(TXS)));
  // Never two commands in one cycle
  assert_one_cmd_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pdEnter, pdExit, srEnter, srExit}));
endmodule

// File: rtl/rank_power_fsm.sv
module rank_power_fsm
  import rankpwr_pkg::*;
#(
  parameter int NBANKS = 8,
  parameter int EVW    = 4,
  parameter int TXP    = 4,
  parameter int TXS    = 10,
  parameter int CNTW   = 32,
  localparam int BANKW = $clog2(NBANKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BANKW-1:0] activeBanks,
  input  logic             rdEmpty,
  input  logic             wrEmpty,
  input  logic             busWrite,
  input  logic [EVW-1:0]   pendingEvents,
  input  logic             refBegin,
  input  logic             refEnd,
  output logic [2:0]       pwrState,
  output logic             lowPower,
  output logic             pdEnter,
  output logic             pdExit,
  output logic             srEnter,
  output logic             srExit,
  output logic             cmdReady,
  output logic [NUM_PWR_STATES-1:0][CNTW-1:0] stateCycles
);
  pwrState_t  state;
  pwrStrobe_t strobe;

  rankpwr_ctrl #(.BANKW(BANKW), .EVW(EVW)) u_ctrl (
    .clk(clk), .rstN(rstN), .activeBanks(activeBanks), .rdEmpty(rdEmpty),
    .wrEmpty(wrEmpty), .busWrite(busWrite), .pendingEvents(pendingEvents),
    .refBegin(refBegin), .refEnd(refEnd), .state(state),
    .lowPower(lowPower), .strobe(strobe)
  );

  rankpwr_datapath #(.TXP(TXP), .TXS(TXS), .CNTW(CNTW)) u_dp (
    .clk(clk), .rstN(rstN), .state(state), .strobe(strobe),
    .pdEnter(pdEnter), .pdExit(pdExit), .srEnter(srEnter), .srExit(srExit),
    .cmdReady(cmdReady), .stateCycles(stateCycles)
  );

  assign pwrState = state;
endmodule

// File: tb/sim_rank_power_fsm.sv
module sim_rank_power_fsm;
  localparam int CLK_PERIOD = 10;
  localparam int TXP = 3;
  localparam int TXS = 6;
  localparam int CNTW = 16;
  localparam int NBANKS = 8;
  localparam int BANKW = $clog2(NBANKS + 1);
  localparam int S_IDLE = 0, S_ACT = 1, S_APD = 2, S_PPD = 3, S_REF = 4, S_SREF = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [BANKW-1:0] activeBanks = '0;
  logic rdEmpty = 1'b0, wrEmpty = 1'b0, busWrite = 1'b0;
  logic [3:0] pendingEvents = '0;
  logic refBegin = 1'b0, refEnd = 1'b0;
  logic [2:0] pwrState;
  logic lowPower, pdEnter, pdExit, srEnter, srExit, cmdReady;
  logic [5:0][CNTW-1:0] stateCycles;

  rank_power_fsm #(.NBANKS(NBANKS), .EVW(4), .TXP(TXP), .TXS(TXS), .CNTW(CNTW)) u0 (
    .clk(clk), .rstN(rstN), .activeBanks(activeBanks), .rdEmpty(rdEmpty),
    .wrEmpty(wrEmpty), .busWrite(busWrite), .pendingEvents(pendingEvents),
    .refBegin(refBegin), .refEnd(refEnd), .pwrState(pwrState),
    .lowPower(lowPower), .pdEnter(pdEnter), .pdExit(pdExit), .srEnter(srEnter),
    .srExit(srExit), .cmdReady(cmdReady), .stateCycles(stateCycles)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int tally[6];
  int expState = S_IDLE;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setIn(int banks, bit rdE, bit wrE, bit bw, int pend, bit rb, bit re);
    activeBanks = BANKW'(banks); rdEmpty = rdE; wrEmpty = wrE; busWrite = bw;
    pendingEvents = 4'(pend); refBegin = rb; refEnd = re;
    #1;
  endtask

  task automatic step();
    tally[expState]++;
    @(posedge clk);
    #1;
  endtask

  // step, then check state and the four pulses {pdEnter,pdExit,srEnter,srExit}
  task automatic go(string tag, int st, int pulses);
    step();
    chk({tag, " state"}, int'(pwrState), st);
    chk({tag, " pulses"}, int'({pdEnter, pdExit, srEnter, srExit}), pulses);
    expState = st;
  endtask

  task automatic wakeWindow(string tag, int len);
    chk({tag, " ready low at exit"}, int'(cmdReady), 0);
    for (int k = 1; k < len; k++) begin
      step();
      chk({tag, " ready still low"}, int'(cmdReady), 0);
    end
    step();
    chk({tag, " ready after window"}, int'(cmdReady), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) tally[i] = 0;
    setIn(0, 0, 1, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 state in reset", int'(pwrState), S_IDLE);
    chk("R1 pulses in reset", int'({pdEnter, pdExit, srEnter, srExit}), 0);
    chk("R1 ready in reset", int'(cmdReady), 1);
    chk("R10 lowPower with traffic", int'(lowPower), 0);
    for (int i = 0; i < 6; i++) chk("R1 counter zero", int'(stateCycles[i]), 0);
    rstN = 1'b1;
    go("R1 idle holds with traffic", S_IDLE, 0);

    // R2 idle -> active
    setIn(2, 0, 1, 0, 0, 0, 0);
    go("R2 idle to active", S_ACT, 0);
    // R3 pending blocks power-down; R4 refBegin ignored in active
    setIn(2, 1, 1, 0, 1, 1, 0);
    chk("R3 lowPower off while pending", int'(lowPower), 0);
    go("R3 R4 active holds", S_ACT, 0);
    // R4 active -> active power-down
    setIn(2, 1, 1, 0, 0, 0, 0);
    chk("R10 lowPower while entering", int'(lowPower), 1);
    go("R4 active to active pdn", S_APD, 4'b1000);
    go("R4 active pdn holds", S_APD, 0);
    chk("R10 lowPower in pdn", int'(lowPower), 1);
    // R5 banks zero does not move active pdn
    setIn(0, 1, 1, 0, 0, 0, 0);
    go("R5 active pdn ignores banks", S_APD, 0);
    // R5 exit on queued write
    setIn(2, 1, 0, 0, 0, 0, 0);
    go("R5 active pdn to active", S_ACT, 4'b0100);
    wakeWindow("R9 txp after active pdn", TXP);
    chk("R9 still active", int'(pwrState), S_ACT);
    // R4 active -> idle
    setIn(0, 0, 0, 0, 0, 0, 0);
    go("R4 active to idle", S_IDLE, 0);
    // R2 idle -> precharge pdn
    setIn(0, 1, 1, 0, 0, 0, 0);
    go("R2 idle to pre pdn", S_PPD, 4'b1000);
    // R6 refBegin from pre pdn
    setIn(0, 1, 1, 0, 0, 1, 0);
    go("R6 pre pdn to refresh", S_REF, 4'b0100);
    setIn(0, 1, 1, 0, 0, 0, 0);
    wakeWindow("R9 txp after pre pdn", TXP);
    chk("R7 refresh held", int'(pwrState), S_REF);
    // R7 refresh end, prior pre pdn, quiet -> self-refresh
    setIn(0, 1, 1, 0, 0, 0, 1);
    chk("R10 lowPower entering sref", int'(lowPower), 1);
    go("R7 refresh to sref", S_SREF, 4'b0010);
    // R8 write queued, bus read: ignored
    setIn(0, 1, 0, 0, 0, 0, 0);
    go("R8 sref ignores writes on read bus", S_SREF, 0);
    go("R8 sref still held", S_SREF, 0);
    // R8 bus turns to write -> exit
    setIn(0, 1, 0, 1, 0, 0, 0);
    go("R8 sref exit on write", S_IDLE, 4'b0001);
    setIn(0, 0, 0, 0, 0, 0, 0);
    wakeWindow("R9 txs after sref", TXS);
    // R2 refresh from idle has priority; R7 returns to idle
    setIn(3, 1, 1, 0, 0, 1, 0);
    go("R2 idle refresh priority", S_REF, 0);
    setIn(0, 1, 1, 0, 0, 0, 1);
    go("R7 refresh prior idle to idle", S_IDLE, 0);
    // R7 prior pre pdn but traffic -> idle
    setIn(0, 1, 1, 0, 0, 0, 0);
    go("R2 idle to pre pdn again", S_PPD, 4'b1000);
    setIn(0, 1, 1, 0, 0, 1, 0);
    go("R6 to refresh again", S_REF, 4'b0100);
    setIn(0, 0, 1, 0, 0, 0, 1);
    go("R7 traffic blocks sref", S_IDLE, 0);
    // R6 pre pdn exit to idle on read
    setIn(0, 1, 1, 0, 0, 0, 0);
    go("R2 idle to pre pdn third", S_PPD, 4'b1000);
    setIn(0, 0, 1, 0, 0, 0, 0);
    go("R6 pre pdn to idle", S_IDLE, 4'b0100);
    // R8 read forces sref exit
    setIn(0, 1, 1, 0, 0, 0, 0);
    go("R2 to pre pdn fourth", S_PPD, 4'b1000);
    setIn(0, 1, 1, 0, 0, 1, 0);
    go("R6 to refresh fourth", S_REF, 4'b0100);
    setIn(0, 1, 1, 0, 0, 0, 1);
    go("R7 to sref again", S_SREF, 4'b0010);
    setIn(0, 0, 1, 0, 0, 0, 0);
    go("R8 sref exit on read", S_IDLE, 4'b0001);
    setIn(0, 0, 1, 0, 0, 0, 0);
    step();
    // R11 counters
    for (int i = 0; i < 6; i++) chk("R11 state cycle counter", int'(stateCycles[i]), tally[i]);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule